// File: doc/BRIEF.md
# ATM Cell Transmit Link-Layer Engine

This block moves ATM cells from a 16-bit user-side cell buffer onto an 8-bit UTOPIA Level 1 transmit port, acting as the link-layer master. It runs in one clock domain, the transmit interface clock. It fetches buffer words with a word address and a one-cycle read strobe. It splits each word into two bytes and drives the active-low enable, the start-of-cell flag and the data byte toward the PHY.

A mode input chooses between two cell sizes. In the 54-byte mode the cell passes through untouched. In the 53-byte mode the sixth header byte (the user-defined byte held in the low half of word 2) is left out without a gap on the line. A cell starts only when the user has one ready and the PHY reports room for it. Once a cell has started it is never cut short. Whether the next cell follows with no idle cycle is decided by polling both conditions in the cycle that carries the final byte.

Top module: `atm_tx_link`

## Requirements
- R1: When idle, a cell starts only in a cycle where user_rdy and phy_clav are both high. In that cycle rd_en is high with rd_addr = 0. In the next cycle tx_en_n is low, tx_soc is high and tx_data carries the upper byte of word 0.
- R2: tx_soc is high only during the first byte of each cell, and only while tx_en_n is low.
- R3: Each word is sent upper byte (bits 15:8) first, then lower byte (bits 7:0). When full_cell = 1, all 54 bytes of words 0 to 26 go out in order on consecutive cycles.
- R4: When full_cell = 0, the lower byte of word 2 is not sent. The cell is 53 consecutive bytes, and the upper byte of word 3 directly follows the upper byte of word 2.
- R5: Each rd_en assertion fetches the next word address in the order 0, 1, ..., 26, and the order then starts again at 0. rd_en is high for single cycles with at least one low cycle between them. The one exception is in 53-byte mode, where the fetch of word 3 directly follows the fetch of word 2.
- R6: Once started, a cell always completes: its full byte count is sent on consecutive cycles and all 27 words are fetched, whatever user_rdy and phy_clav do meanwhile.
- R7: If user_rdy and phy_clav are both high in the cycle that carries a cell's final byte, the next cell's first byte follows in the next cycle with tx_en_n still low.
- R8: Otherwise tx_en_n is high in the cycle after the final byte, and rd_en stays low until a new cell starts under R1.
- R9: While rst is high, tx_en_n is high, tx_soc is low and rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit interface clock |
| rst | input | 1 | Synchronous reset, active high |
| full_cell | input | 1 | 1: 54-byte cells; 0: 53-byte cells with the user-defined header byte dropped |
| user_rdy | input | 1 | User buffer holds a cell ready to send |
| phy_clav | input | 1 | PHY has room for a cell |
| rd_en | output | 1 | Buffer read strobe; the word is taken at the end of this cycle |
| rd_addr | output | 5 | Word address within the cell, 0 to 26 |
| rd_data | input | 16 | Buffer word, valid while rd_en is high |
| tx_en_n | output | 1 | Transmit enable toward the PHY, active low |
| tx_soc | output | 1 | Start-of-cell flag |
| tx_data | output | 8 | Transmit data byte |

## Verification
The hardest situation to reach is the one-cycle polling window at the end of a cell. A withdrawal of user_rdy or phy_clav one cycle earlier or later flips the outcome between a back-to-back cell and a clean stop. The stimulus starts a cell, waits a swept number of cycles, and then drops one of the two conditions, alternating which one. The sweep covers every position from the first byte to past the final byte, in both cell sizes. For each position, the number of cells started and the number of buffer fetches are compared with counts computed from the drop position.

// File: rtl/atm_tx_link.sv
module atm_tx_link #(
  parameter int CELL_WORDS = 27,
  parameter int UDF_WORD   = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          full_cell,
  input  logic                          user_rdy,
  input  logic                          phy_clav,
  output logic                          rd_en,
  output logic [$clog2(CELL_WORDS)-1:0] rd_addr,
  input  logic [15:0]                   rd_data,
  output logic                          tx_en_n,
  output logic                          tx_soc,
  output logic [7:0]                    tx_data
);
  localparam int AW = $clog2(CELL_WORDS);
  localparam logic [AW-1:0] LAST = AW'(CELL_WORDS - 1);
  localparam logic [AW-1:0] AFTER_UDF = AW'(UDF_WORD + 1);

  logic          act, lo_ph, soc_q;
  logic [AW-1:0] addr;
  logic [7:0]    lo_q, out_q;

  wire go     = user_rdy & phy_clav;
  wire last_w = (addr == '0);
  wire drop   = act & ~lo_ph & ~full_cell & (addr == AFTER_UDF);
  wire lo_rd  = act & lo_ph & (~last_w | go);

  assign rd_en   = ~rst & ((~act & go) | drop | lo_rd);
  assign rd_addr = addr;
  assign tx_en_n = ~act;
  assign tx_soc  = soc_q;
  assign tx_data = out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act   <= 1'b0;
      lo_ph <= 1'b0;
      soc_q <= 1'b0;
      addr  <= '0;
      lo_q  <= '0;
      out_q <= '0;
    end else if (rd_en) begin
      out_q <= rd_data[15:8];
      lo_q  <= rd_data[7:0];
      act   <= 1'b1;
      lo_ph <= 1'b0;
      soc_q <= (addr == '0);
      addr  <= (addr == LAST) ? '0 : addr + 1'b1;
    end else if (act & ~lo_ph) begin
      out_q <= lo_q;
      lo_ph <= 1'b1;
      soc_q <= 1'b0;
    end else begin
      act   <= 1'b0;
      lo_ph <= 1'b0;
      soc_q <= 1'b0;
    end
  end

  p_start_needs_go_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_en_n) |-> $past(user_rdy && phy_clav));

  p_soc_in_cell_r2: assert property (@(posedge clk) disable iff (rst)
    tx_soc |-> !tx_en_n);

  p_addr_range_r5: assert property (@(posedge clk) disable iff (rst)
    rd_addr <= LAST);

  p_addr_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == LAST) |=> rd_addr == '0);

  p_end_on_last_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_en_n) |-> $past(rd_addr) == '0);

  p_b2b_soc_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == '0 && !tx_en_n) |=> (tx_soc && !tx_en_n));
endmodule

// File: tb/atm_tx_link_tb_top.sv
`timescale 1ns/1ps
module atm_tx_link_tb_top;
  logic clk = 0, rst = 1, full = 1, ur = 0, clav = 0;
  logic rd_en, tx_en_n, tx_soc;
  logic [4:0] rd_addr;
  logic [15:0] rd_data;
  logic [7:0] tx_data;
  logic [1:0] cid;

  int chk = 0, fail = 0, mon_chk = 0, mon_fail = 0;
  int cyc = 0, mb = 0, mc = 0, ra = 0, socs = 0, rd_pulses = 0;
  logic prev_rd = 0;
  logic [4:0] prev_addr = 0;

  always #4 clk = ~clk;

  atm_tx_link dut_i (
    .clk(clk), .rst(rst), .full_cell(full), .user_rdy(ur), .phy_clav(clav),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .tx_en_n(tx_en_n), .tx_soc(tx_soc), .tx_data(tx_data));

  assign rd_data = {cid, 1'b0, rd_addr, cid, 1'b1, rd_addr};

  always @(posedge clk)
    if (rst) cid <= 0;
    else if (rd_en && rd_addr == 5'd26) cid <= cid + 1'b1;

  function automatic logic [7:0] exp_byte(logic [1:0] c, int j, logic f);
    int k;
    k = (f || j < 5) ? j : j + 1;
    return {c, k[0], k[5:1]};
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", (chk + mon_chk) - (fail + mon_fail), chk + mon_chk);
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    chk++;
    if (!ok) begin
      fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int len;
    logic [7:0] eb;
    len = full ? 54 : 53;
    cyc++;
    if (cyc > 150000) begin
      mon_fail++;
      mon_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
      $finish;
    end
    if (rst) begin
      mb = 0; mc = 0; ra = 0; prev_rd = 0;
    end else begin
      if (rd_en) begin
        mon_chk++;
        if (rd_addr != 5'(ra)) begin
          mon_fail++;
          $display("FAIL R5 address actual=%0d expected=%0d", rd_addr, ra);
        end
        mon_chk++;
        if (prev_rd && !(!full && prev_addr == 5'd2 && rd_addr == 5'd3)) begin
          mon_fail++;
          $display("FAIL R5 adjacent strobe actual=%0d expected=%0d", rd_addr, -1);
        end
        ra = (ra == 26) ? 0 : ra + 1;
        rd_pulses++;
      end
      prev_rd = rd_en;
      prev_addr = rd_addr;
      if (!tx_en_n) begin
        eb = exp_byte(2'(mc), mb, full);
        mon_chk++;
        if (tx_data != eb) begin
          mon_fail++;
          $display("FAIL %s byte %0d actual=%0d expected=%0d", full ? "R3" : "R4", mb, tx_data, eb);
        end
        mon_chk++;
        if (tx_soc != (mb == 0)) begin
          mon_fail++;
          $display("FAIL R2 soc actual=%0d expected=%0d", tx_soc, mb == 0);
        end
        if (mb == 0) socs++;
        mb++;
        if (mb == len) begin mb = 0; mc++; end
      end else if (mb != 0) begin
        mon_chk++;
        mon_fail++;
        $display("FAIL R6 cell cut at byte actual=%0d expected=%0d", mb, len);
        mb = 0;
      end
    end
  end

  task automatic at_drive();
    @(posedge clk); #1;
  endtask

  initial begin
    int run, ns, p0, s0, expc, len;
    ur = 1; clav = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(tx_en_n && !tx_soc && !rd_en, "R9 reset outputs", {tx_en_n, tx_soc, rd_en}, 3'b100);
    end
    at_drive(); rst = 0; ur = 1; clav = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(!rd_en && tx_en_n, "R1 no phy room", {rd_en, tx_en_n}, 2'b01);
    end
    at_drive(); ur = 0; clav = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(!rd_en && tx_en_n, "R1 no user cell", {rd_en, tx_en_n}, 2'b01);
    end
    at_drive(); ur = 1; clav = 1;
    @(negedge clk);
    check(rd_en && rd_addr == 0, "R1 first fetch", {rd_en, rd_addr}, 6'b100000);
    @(negedge clk);
    check(!tx_en_n && tx_soc && tx_data == 8'h00, "R1 first byte", {tx_en_n, tx_soc, tx_data}, 10'b0100000000);
    run = 1; ns = 1;
    while (ns < 3 && run < 400) begin
      @(negedge clk);
      if (!tx_en_n) run++;
      if (tx_soc) ns++;
    end
    at_drive(); ur = 0; clav = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (tx_en_n) break;
      run++;
    end
    check(run == 162, "R7 back-to-back run length", run, 162);
    repeat (10) @(negedge clk);
    check(rd_pulses == 81, "R8 fetches after stop", rd_pulses, 81);
    check(socs == 3, "R7 cells sent", socs, 3);

    for (int m = 1; m >= 0; m--) begin
      at_drive(); rst = 1; ur = 0; clav = 0; full = m[0];
      repeat (3) at_drive();
      rst = 0;
      len = full ? 54 : 53;
      for (int k = 1; k <= len + 2; k++) begin
        p0 = rd_pulses; s0 = socs;
        at_drive(); ur = 1; clav = 1;
        for (int i = 0; i < 10; i++) begin
          @(negedge clk);
          if (tx_soc) break;
        end
        repeat (k) at_drive();
        if (k % 2 == 1) ur = 0; else clav = 0;
        repeat (2 * len + 8) @(negedge clk);
        expc = (k <= len - 1) ? 1 : 2;
        check(socs - s0 == expc, "R7 R8 cells for drop position", socs - s0, expc);
        check(rd_pulses - p0 == 27 * expc, "R6 R8 fetch count", rd_pulses - p0, 27 * expc);
        check(tx_en_n && !rd_en, "R8 idle after cell", {tx_en_n, rd_en}, 2'b10);
        at_drive(); ur = 0; clav = 0;
      end
    end
    summary();
    $finish;
  end
endmodule